// File: doc/BRIEF.md
# Shared Buffer Slot Allocator

This block sits between the time-stamping stage and the crossbar that fills the shared buffers of a router. Each cycle up to `N_IN` flits arrive that already carry a departure stamp, a virtual-channel tag, an out-port and a payload. The allocator places every such flit into one of `N_BUF` shared buffers. The flit lands in the entry whose slot index equals its stamp. A flit that cannot be placed is flagged as failed in the same cycle so that it can go back for a new stamp.

Each shared buffer is a row of `SLOTS` entries. Any flit may go to any buffer, and any buffer may feed any out-port. A buffer takes at most `SPEEDUP` writes per cycle, each into a different slot. On every clock edge all entries move down one slot. The entry that was at slot 0 is dropped, so slot 0 of every buffer is presented on the read side for one cycle, tagged with its out-port. A stamp of `k` is relative to the write edge: the flit is shown `k + 1` cycles after the cycle in which it was offered.

The ingress side uses a request/response handshake with no back-pressure. Every valid flit gets a decision combinationally in the cycle it is offered: either `acc_o` or `fail_o` is set. The write happens on the next edge. The read side cannot stall, because its timing is fixed by the slot position, so it has a valid flag and no ready.

Top module: `sbuf_slot_alloc`

## Requirements
- R1: While reset is held and in the first cycle after it, every `rd_vld_o` bit is low. No flit is accepted unless offered.
- R2: In any cycle, each input with `in_vld_i` high has exactly one of `acc_o` and `fail_o` high. An input with `in_vld_i` low has neither.
- R3: A flit accepted with stamp `k` in cycle `c` is shown in cycle `c + 1 + k` on the `rd_*_o` lane of the buffer given by `buf_o`, with its own out-port and payload. The lane is invalid in the cycles before that.
- R4: Two flits never occupy the same slot of the same buffer. A slot already holding a flit, or taken earlier in the same cycle, makes that buffer unusable for that stamp.
- R5: No buffer accepts more than `SPEEDUP` flits in one cycle. With `SPEEDUP` = 2, a third flit goes to another buffer.
- R6: A flit is accepted only if it departs strictly later than every still-pending flit of the same VC, counting flits accepted earlier in the same cycle. Otherwise it fails. A flit that failed sets no constraint.
- R7: The buffer search starts at a pointer that is 0 in the first cycle after reset and advances by one (modulo `N_BUF`) every cycle. Lower input indices are served first.
- R8: A failed flit is written nowhere. The slot it asked for keeps its previous content.
- R9: When no buffer has its stamp slot free and write capacity left, the flit fails.
- R10: A slot-0 entry is shown for exactly one cycle and is invalid afterwards unless a later entry moves into slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | N_IN | Flit offered, one bit per input |
| in_vc_i | input | N_IN*VW | VC tag per input |
| in_slot_i | input | N_IN*SW | Departure stamp per input |
| in_port_i | input | N_IN*PW | Out-port per input |
| in_data_i | input | N_IN*DW | Payload per input |
| acc_o | output | N_IN | Flit accepted, written on next edge |
| fail_o | output | N_IN | Flit refused, to be re-stamped |
| buf_o | output | N_IN*BW | Chosen buffer of an accepted flit |
| rd_vld_o | output | N_BUF | Slot 0 of each buffer holds a flit |
| rd_port_o | output | N_BUF*PW | Out-port of each slot-0 flit |
| rd_data_o | output | N_BUF*DW | Payload of each slot-0 flit |

## Verification
The hardest case to reach is a refusal caused by a flit already stored from an earlier cycle. It has to be lined up with the rotating search pointer, because after one edge the stored flit's stamp has moved down by one. The bench resets and then counts cycles from the release. It places a flit with stamp 3 in cycle 0. In cycle 1 it offers two flits with stamp 2 that point at the same departure. The first takes the buffer the pointer now favours, and the second finds the stored flit in the other buffer and fails. Cross-cycle VC ordering is reached the same way. Same-cycle conflicts are swept from a vector table applied right after reset.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  // index width that stays at least one bit for degenerate sizes
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sbuf_bank.sv
module sbuf_bank #(
  parameter int N_IN    = 3,
  parameter int SLOTS   = 4,
  parameter int SPEEDUP = 2,
  parameter int SW      = 2,
  parameter int PW      = 2,
  parameter int DW      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_IN-1:0]      wr_en,
  input  logic [N_IN*SW-1:0]   wr_slot,
  input  logic [N_IN*PW-1:0]   wr_port,
  input  logic [N_IN*DW-1:0]   wr_data,
  output logic                 rd_vld,
  output logic [PW-1:0]        rd_port,
  output logic [DW-1:0]        rd_data,
  output logic [SLOTS-1:0]     occ_next
);
  logic [SLOTS-1:0] vld_q, vld_d;
  logic [PW-1:0]    port_q [SLOTS];
  logic [PW-1:0]    port_d [SLOTS];
  logic [DW-1:0]    data_q [SLOTS];
  logic [DW-1:0]    data_d [SLOTS];

  // occupancy as seen after the coming shift
  always_comb begin
    for (int s = 0; s < SLOTS; s++)
      occ_next[s] = (s < SLOTS - 1) ? vld_q[(s + 1) % SLOTS] : 1'b0;
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      vld_d[s]  = occ_next[s];
      port_d[s] = port_q[(s + 1) % SLOTS];
      data_d[s] = data_q[(s + 1) % SLOTS];
    end
    for (int i = 0; i < N_IN; i++) begin
      if (wr_en[i]) begin
        vld_d[wr_slot[i*SW +: SW]]  = 1'b1;
        port_d[wr_slot[i*SW +: SW]] = wr_port[i*PW +: PW];
        data_d[wr_slot[i*SW +: SW]] = wr_data[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        port_q[s] <= '0;
        data_q[s] <= '0;
      end
    end else begin
      vld_q <= vld_d;
      for (int s = 0; s < SLOTS; s++) begin
        port_q[s] <= port_d[s];
        data_q[s] <= data_d[s];
      end
    end
  end

  assign rd_vld  = vld_q[0];
  assign rd_port = port_q[0];
  assign rd_data = data_q[0];

  assert_speedup_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_en) <= SPEEDUP);

  for (genvar i = 0; i < N_IN; i++) begin : g_chk
    assert_slot_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |-> !occ_next[wr_slot[i*SW +: SW]]);
    assert_slot0_shown_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[i] && wr_slot[i*SW +: SW] == '0) |=> rd_vld);
    for (genvar j = i + 1; j < N_IN; j++) begin : g_pair
      assert_distinct_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[i] && wr_en[j]) |-> (wr_slot[i*SW +: SW] != wr_slot[j*SW +: SW]));
    end
  end
endmodule

// File: rtl/sbuf_vc_order.sv
module sbuf_vc_order #(
  parameter int N_IN = 3,
  parameter int VCS  = 4,
  parameter int VW   = 2,
  parameter int SW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IN-1:0]    grant,
  input  logic [N_IN*VW-1:0] in_vc,
  input  logic [N_IN*SW-1:0] in_slot,
  output logic [VCS-1:0]     vc_live,
  output logic [VCS*SW-1:0]  vc_last
);
  logic [VCS-1:0]    live_d;
  logic [VCS*SW-1:0] last_d;

  always_comb begin
    for (int v = 0; v < VCS; v++) begin
      live_d[v]          = vc_live[v] && (vc_last[v*SW +: SW] != '0);
      last_d[v*SW +: SW] = vc_last[v*SW +: SW] - SW'(1);
      for (int i = 0; i < N_IN; i++) begin
        if (grant[i] && in_vc[i*VW +: VW] == VW'(v)) begin
          live_d[v]          = 1'b1;
          last_d[v*SW +: SW] = in_slot[i*SW +: SW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vc_live <= '0;
      vc_last <= '0;
    end else begin
      vc_live <= live_d;
      vc_last <= last_d;
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_chk
    assert_vc_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && vc_live[in_vc[i*VW +: VW]] && vc_last[in_vc[i*VW +: VW]*SW +: SW] != '0)
        |-> (in_slot[i*SW +: SW] >= vc_last[in_vc[i*VW +: VW]*SW +: SW]));
  end
endmodule

// File: rtl/sbuf_pick.sv
module sbuf_pick #(
  parameter int N_IN    = 3,
  parameter int N_BUF   = 2,
  parameter int SLOTS   = 4,
  parameter int SPEEDUP = 2,
  parameter int VCS     = 4,
  parameter int VW      = 2,
  parameter int SW      = 2,
  parameter int BW      = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        in_vld,
  input  logic [N_IN*VW-1:0]     in_vc,
  input  logic [N_IN*SW-1:0]     in_slot,
  input  logic [BW-1:0]          rr,
  input  logic [VCS-1:0]         vc_live,
  input  logic [VCS*SW-1:0]      vc_last,
  input  logic [N_BUF*SLOTS-1:0] occ,
  output logic [N_IN-1:0]        accept,
  output logic [N_IN-1:0]        fail,
  output logic [N_IN*BW-1:0]     bufsel
);
  localparam int CW = $clog2(SPEEDUP + 1);
  localparam logic [CW-1:0] CAP = CW'(SPEEDUP);

  logic [SLOTS-1:0] taken [N_BUF];
  logic [CW-1:0]    cnt   [N_BUF];
  logic [VCS-1:0]   plive;
  logic [SW-1:0]    plast [VCS];
  logic [SW-1:0]    s;
  logic [VW-1:0]    v;
  logic [BW-1:0]    cand, pick;
  logic             found, in_order;

  always_comb begin
    for (int b = 0; b < N_BUF; b++) begin
      taken[b] = occ[b*SLOTS +: SLOTS];
      cnt[b]   = '0;
    end
    for (int k = 0; k < VCS; k++) begin
      plive[k] = vc_live[k] && (vc_last[k*SW +: SW] != '0);
      plast[k] = vc_last[k*SW +: SW] - SW'(1);
    end
    accept = '0;
    fail   = '0;
    bufsel = '0;
    s = '0; v = '0; cand = '0; pick = '0; found = 1'b0; in_order = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (in_vld[i]) begin
        s        = in_slot[i*SW +: SW];
        v        = in_vc[i*VW +: VW];
        in_order = !plive[v] || (s > plast[v]);
        found    = 1'b0;
        pick     = '0;
        for (int j = 0; j < N_BUF; j++) begin
          cand = BW'((int'(rr) + j) % N_BUF);
          if (!found && in_order && cnt[cand] < CAP && !taken[cand][s]) begin
            found = 1'b1;
            pick  = cand;
          end
        end
        if (found) begin
          accept[i]            = 1'b1;
          bufsel[i*BW +: BW]   = pick;
          taken[pick][s]       = 1'b1;
          cnt[pick]            = cnt[pick] + CW'(1);
          plive[v]             = 1'b1;
          plast[v]             = s;
        end else begin
          fail[i] = 1'b1;
        end
      end
    end
  end

  assert_one_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((accept | fail) == in_vld) && ((accept & fail) == '0));
endmodule

// File: rtl/sbuf_slot_alloc.sv
module sbuf_slot_alloc #(
  parameter int N_IN    = 3,
  parameter int N_BUF   = 2,
  parameter int SLOTS   = 4,
  parameter int SPEEDUP = 2,
  parameter int VCS     = 4,
  parameter int PORTS   = 4,
  parameter int DW      = 8,
  localparam int VW     = sbuf_pkg::idx_w(VCS),
  localparam int SW     = sbuf_pkg::idx_w(SLOTS),
  localparam int PW     = sbuf_pkg::idx_w(PORTS),
  localparam int BW     = sbuf_pkg::idx_w(N_BUF)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_IN-1:0]       in_vld_i,
  input  logic [N_IN*VW-1:0]    in_vc_i,
  input  logic [N_IN*SW-1:0]    in_slot_i,
  input  logic [N_IN*PW-1:0]    in_port_i,
  input  logic [N_IN*DW-1:0]    in_data_i,
  output logic [N_IN-1:0]       acc_o,
  output logic [N_IN-1:0]       fail_o,
  output logic [N_IN*BW-1:0]    buf_o,
  output logic [N_BUF-1:0]      rd_vld_o,
  output logic [N_BUF*PW-1:0]   rd_port_o,
  output logic [N_BUF*DW-1:0]   rd_data_o
);
  logic [BW-1:0]          rr_q;
  logic [VCS-1:0]         vc_live;
  logic [VCS*SW-1:0]      vc_last;
  logic [N_BUF*SLOTS-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rr_q <= '0;
    else if (rr_q == BW'(N_BUF - 1))  rr_q <= '0;
    else                              rr_q <= rr_q + BW'(1);
  end

  sbuf_pick #(.N_IN(N_IN), .N_BUF(N_BUF), .SLOTS(SLOTS), .SPEEDUP(SPEEDUP),
              .VCS(VCS), .VW(VW), .SW(SW), .BW(BW)) u_pick (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld_i), .in_vc(in_vc_i),
    .in_slot(in_slot_i), .rr(rr_q), .vc_live(vc_live), .vc_last(vc_last),
    .occ(occ), .accept(acc_o), .fail(fail_o), .bufsel(buf_o));

  sbuf_vc_order #(.N_IN(N_IN), .VCS(VCS), .VW(VW), .SW(SW)) u_order (
    .clk(clk), .rst_n(rst_n), .grant(acc_o), .in_vc(in_vc_i),
    .in_slot(in_slot_i), .vc_live(vc_live), .vc_last(vc_last));

  for (genvar b = 0; b < N_BUF; b++) begin : g_bank
    logic [N_IN-1:0] wen;
    for (genvar i = 0; i < N_IN; i++) begin : g_wen
      assign wen[i] = acc_o[i] && (buf_o[i*BW +: BW] == BW'(b));
    end
    sbuf_bank #(.N_IN(N_IN), .SLOTS(SLOTS), .SPEEDUP(SPEEDUP), .SW(SW),
                .PW(PW), .DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wen), .wr_slot(in_slot_i),
      .wr_port(in_port_i), .wr_data(in_data_i), .rd_vld(rd_vld_o[b]),
      .rd_port(rd_port_o[b*PW +: PW]), .rd_data(rd_data_o[b*DW +: DW]),
      .occ_next(occ[b*SLOTS +: SLOTS]));
  end

  assert_no_write_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o & acc_o) == '0);
  assert_rr_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rr_q == '0);
endmodule

// File: tb/sbuf_slot_alloc_bench.sv
`timescale 1ns/1ps
module sbuf_slot_alloc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  in_vld;
  logic [5:0]  in_vc, in_slot, in_port;
  logic [23:0] in_data;
  logic [2:0]  acc, fail, bsel;
  logic [1:0]  rd_vld;
  logic [3:0]  rd_port;
  logic [15:0] rd_data;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sbuf_slot_alloc u_sbuf_slot_alloc (
    .clk(clk), .rst_n(rst_n), .in_vld_i(in_vld), .in_vc_i(in_vc),
    .in_slot_i(in_slot), .in_port_i(in_port), .in_data_i(in_data),
    .acc_o(acc), .fail_o(fail), .buf_o(bsel), .rd_vld_o(rd_vld),
    .rd_port_o(rd_port), .rd_data_o(rd_data));

  // {valid, vc2 vc1 vc0, slot2 slot1 slot0, exp_acc, exp_fail, exp_buf}
  localparam logic [23:0] VEC [8] = '{
    {3'b111, 2'd2,2'd1,2'd0, 2'd2,2'd1,2'd0, 3'b111, 3'b000, 3'b100},
    {3'b111, 2'd2,2'd1,2'd0, 2'd0,2'd0,2'd0, 3'b011, 3'b100, 3'b010},
    {3'b111, 2'd0,2'd0,2'd0, 2'd3,2'd2,2'd1, 3'b111, 3'b000, 3'b100},
    {3'b111, 2'd0,2'd0,2'd0, 2'd3,2'd1,2'd2, 3'b101, 3'b010, 3'b000},
    {3'b111, 2'd0,2'd0,2'd0, 2'd2,2'd1,2'd1, 3'b101, 3'b010, 3'b000},
    {3'b010, 2'd0,2'd1,2'd0, 2'd0,2'd3,2'd0, 3'b010, 3'b000, 3'b000},
    {3'b000, 2'd0,2'd0,2'd0, 2'd0,2'd0,2'd0, 3'b000, 3'b000, 3'b000},
    {3'b111, 2'd1,2'd0,2'd0, 2'd0,2'd0,2'd0, 3'b101, 3'b010, 3'b100}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    in_vld = '0; in_vc = '0; in_slot = '0; in_port = '0; in_data = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;   // now in cycle 0 after reset, pointer at buffer 0
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle();
    // R1: reset state
    do_reset();
    #1;
    check("R1 rd_vld after reset", 32'(rd_vld), 32'd0);
    check("R1 no accept when idle", 32'(acc | fail), 32'd0);

    // vector table: R2 R4 R5 R6 R7 R9 same-cycle decisions at pointer 0
    for (int k = 0; k < 8; k++) begin
      do_reset();
      in_vld  = VEC[k][23:21];
      in_vc   = VEC[k][20:15];
      in_slot = VEC[k][14:9];
      in_port = {2'd2, 2'd1, 2'd0};
      in_data = 24'h332211;
      #1;
      check($sformatf("R2 accept vec%0d", k), 32'(acc), 32'(VEC[k][8:6]));
      check($sformatf("R9 fail vec%0d", k), 32'(fail), 32'(VEC[k][5:3]));
      check($sformatf("R5 buffer vec%0d", k), 32'(bsel & acc), 32'(VEC[k][2:0]));
      @(negedge clk);
      idle();
    end

    // R3 / R10: stamp 2 offered in cycle 0 shows in cycle 3 only
    do_reset();
    in_vld = 3'b001; in_vc = 6'd0; in_slot = 6'd2; in_port = 6'd3; in_data = 24'h0000A5;
    #1;
    check("R3 accept stamp2", 32'(acc), 32'd1);
    @(negedge clk); idle(); #1;
    check("R3 cycle1 empty", 32'(rd_vld), 32'd0);
    @(negedge clk); #1;
    check("R3 cycle2 empty", 32'(rd_vld), 32'd0);
    @(negedge clk); #1;
    check("R3 cycle3 valid", 32'(rd_vld), 32'd1);
    check("R3 cycle3 port", 32'(rd_port[1:0]), 32'd3);
    check("R3 cycle3 data", 32'(rd_data[7:0]), 32'hA5);
    @(negedge clk); #1;
    check("R10 cleared after readout", 32'(rd_vld), 32'd0);

    // R4 / R7 / R8: stored flit blocks a later same-departure request
    do_reset();
    in_vld = 3'b001; in_vc = 6'd0; in_slot = 6'd3; in_port = 6'd1; in_data = 24'h000011;
    #1;
    check("R7 cycle0 uses buffer0", 32'(bsel[0]), 32'd0);
    @(negedge clk);
    in_vld = 3'b011; in_vc = {2'd0, 2'd2, 2'd1}; in_slot = {2'd0, 2'd2, 2'd2};
    in_port = {2'd0, 2'd3, 2'd2}; in_data = 24'h003322;
    #1;
    check("R4 occupied slot refused", 32'(acc), 32'b001);
    check("R4 fail flag", 32'(fail), 32'b010);
    check("R7 cycle1 starts at buffer1", 32'(bsel[0]), 32'd1);
    @(negedge clk); idle();
    repeat (2) @(negedge clk);
    #1;
    check("R3 both departures cycle4", 32'(rd_vld), 32'b11);
    check("R8 buffer0 keeps stored data", 32'(rd_data[7:0]), 32'h11);
    check("R8 buffer1 data", 32'(rd_data[15:8]), 32'h22);

    // R6: ordering against a flit granted in an earlier cycle
    do_reset();
    in_vld = 3'b001; in_vc = 6'd3; in_slot = 6'd2; in_port = '0; in_data = 24'h000044;
    #1;
    check("R6 first flit accepted", 32'(acc), 32'd1);
    @(negedge clk);
    in_vld = 3'b111; in_vc = {2'd3, 2'd3, 2'd3}; in_slot = {2'd2, 2'd2, 2'd1};
    in_data = 24'h776655;
    #1;
    check("R6 accept pattern", 32'(acc), 32'b010);
    check("R6 fail pattern", 32'(fail), 32'b101);
    check("R6 later flit buffer", 32'(bsel[1]), 32'd1);
    @(negedge clk); idle(); #1;
    check("R6 first departs cycle3 not yet", 32'(rd_vld), 32'd0);
    @(negedge clk); #1;
    check("R6 first departs cycle3", 32'(rd_vld), 32'b01);
    @(negedge clk); #1;
    check("R6 second departs cycle4", 32'(rd_vld), 32'b10);
    check("R6 second data", 32'(rd_data[15:8]), 32'h66);

    finish_run();
  end
endmodule